// File: doc/BRIEF.md
# Dual-Symbol Code Register and Byte Emitter

This block is the back half of a two-symbols-per-cycle binary arithmetic encoder. It keeps the code register and the count of bits left before the next byte boundary. Each cycle it accepts one pair of coded symbols. For each symbol it receives three things from the interval stage: the less-probable-symbol probability, whether the symbol was the more probable one, and the renormalization shift count. The block applies the first symbol's addition and shift, then the second symbol's addition and shift, on the state the first one left. It releases every compressed byte that the two shifts complete, which can be zero to four bytes in one cycle. A byte that follows 0xFF carries one stuffed zero bit, and a carry out of the code register ripples into the byte held from the previous boundary.

Released bytes appear on four byte lanes, packed from lane 0 upward in stream order, each with its own valid flag, so that four downstream queues can capture them in parallel. At the end of a code block a flush cycle pads the code register, which needs the current interval. It then pushes out the last two byte boundaries and the final held byte, and returns the register to its start state for the next block.

Top module: `mq_dual_emitter`

## Requirements
- R1: After reset or a flush, C is 0 and the first byte boundary is reached after exactly 12 shifts. The placeholder byte held before the stream is never emitted. No lane is valid in the cycle after reset.
- R2: A symbol flagged as more probable adds its 16-bit probability to C before its shift. A less probable symbol leaves C unchanged before its shift.
- R3: A shift count n produces a byte boundary each time the remaining count reaches the bits-left counter, which holds a value from 1 to 12 between cycles. A shift that stops short only decrements the counter.
- R4: At a boundary with no carry and a held byte other than 0xFF, the new held byte is C[26:19], C keeps bits 18:0, and the counter reloads to 8.
- R5: At a boundary where the held byte is 0xFF, the new held byte is C[27:20], C keeps bits 19:0, and the counter reloads to 7. The following byte therefore spans only 7 shifts.
- R6: When C bit 27 is set at a boundary and the held byte is not 0xFF, the held byte is incremented before it is released. If the increment yields 0xFF, the R5 stuffed path is taken, with the carry bit cleared.
- R7: A byte is released only at the boundary after the one that captured it. Released bytes are in stream order.
- R8: The second symbol of a pair works on the state left by the first. A pair can release up to four bytes, placed on lanes 0 upward with contiguous valid flags.
- R9: A cycle with neither pair valid nor flush releases nothing and leaves the coder state unchanged.
- R10: A flush pads C using the supplied interval A: it sets the low 16 bits and subtracts 0x8000 if that reaches C+A. It then makes two boundaries, each after shifting by the counter, and releases the final held byte unless it is 0xFF. At most three lanes are valid, and the state returns to the R1 start.
- R11: Lanes and valid flags are registered and present the result of a pair or a flush in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol pair is presented this cycle |
| flush | input | 1 | End-of-block drain this cycle |
| sym0_qe | input | 16 | Probability value of the first symbol |
| sym0_mps | input | 1 | First symbol is the more probable one |
| sym0_shift | input | 4 | Renormalization shift of the first symbol |
| sym1_qe | input | 16 | Probability value of the second symbol |
| sym1_mps | input | 1 | Second symbol is the more probable one |
| sym1_shift | input | 4 | Renormalization shift of the second symbol |
| flush_ival | input | 16 | Current interval A, used only during a flush |
| lane_byte | output | 32 | Four released bytes, lane k in bits 8k+7:8k |
| lane_vld | output | 4 | Valid flag per lane |

## Verification
The assertions assume that the interval stage never asserts a pair and a flush in the same cycle. They also assume that no single symbol's shift would need a third byte boundary, which is possible only for a 15-bit shift starting from one bit left with two stuffed reloads. The stimulus presents pairs and flushes in separate cycles and limits random shifts to 14, so both conditions hold by construction. Directed vectors still reach the 15-bit shift, the carry into 0xFE and the stuffed path.

// File: rtl/mqce_pkg.sv
package mqce_pkg;

    localparam int C_W       = 32;
    localparam int CT_W      = 4;
    localparam int QE_W      = 16;
    localparam int SH_W      = 4;
    localparam int CARRY_BIT = 27;
    localparam int BPS       = 2;   // byte boundaries one symbol may reach

    localparam logic [CT_W-1:0] CT_START = CT_W'(12);
    localparam logic [CT_W-1:0] CT_FULL  = CT_W'(8);
    localparam logic [CT_W-1:0] CT_STUFF = CT_W'(7);

    localparam logic [C_W-1:0] KEEP_FULL  = (C_W'(1) << (CARRY_BIT - 8)) - C_W'(1);
    localparam logic [C_W-1:0] KEEP_STUFF = (C_W'(1) << (CARRY_BIT - 7)) - C_W'(1);
    localparam logic [C_W-1:0] PAD_ONES   = (C_W'(1) << QE_W) - C_W'(1);
    localparam logic [C_W-1:0] PAD_HALF   = C_W'(1) << (QE_W - 1);

    typedef struct packed {
        logic [C_W-1:0]  c;
        logic [CT_W-1:0] ct;
        logic [7:0]      hold;
        logic            live;
    } coder_t;

    localparam coder_t CODER_INIT = '{c: '0, ct: CT_START, hold: 8'h00, live: 1'b0};

    typedef struct packed {
        coder_t     st;
        logic [7:0] byte_out;
        logic       fire;
    } bo_t;

    typedef struct packed {
        coder_t           st;
        logic [BPS*8-1:0] bytes;
        logic [BPS-1:0]   fire;
        logic             spill;
    } sym_t;

    typedef struct packed {
        logic [23:0] bytes;
        logic [2:0]  fire;
    } fl_t;

    // One byte boundary: release the held byte, capture the next one.
    function automatic bo_t byte_step(coder_t s);
        bo_t        r;
        logic [7:0] bumped;
        r          = '0;
        r.st       = s;
        r.fire     = s.live;
        r.byte_out = s.hold;
        r.st.live  = 1'b1;
        bumped     = s.hold + 8'd1;
        if (s.hold == 8'hFF) begin
            r.st.hold = s.c[CARRY_BIT -: 8];
            r.st.c    = s.c & KEEP_STUFF;
            r.st.ct   = CT_STUFF;
        end else if (!s.c[CARRY_BIT]) begin
            r.st.hold = s.c[CARRY_BIT-1 -: 8];
            r.st.c    = s.c & KEEP_FULL;
            r.st.ct   = CT_FULL;
        end else begin
            r.byte_out = bumped;
            if (bumped == 8'hFF) begin
                r.st.hold = {1'b0, s.c[CARRY_BIT-1 -: 7]};
                r.st.c    = s.c & KEEP_STUFF;
                r.st.ct   = CT_STUFF;
            end else begin
                r.st.hold = s.c[CARRY_BIT-1 -: 8];
                r.st.c    = s.c & KEEP_FULL;
                r.st.ct   = CT_FULL;
            end
        end
        return r;
    endfunction

    // One symbol: conditional addition, then shift with up to BPS boundaries.
    function automatic sym_t sym_step(coder_t s_in, logic [QE_W-1:0] qe,
                                      logic is_mps, logic [SH_W-1:0] n);
        sym_t          r;
        coder_t        s;
        bo_t           b;
        logic [SH_W:0] rem;
        r = '0;
        s = s_in;
        if (is_mps) s.c = s.c + {{(C_W-QE_W){1'b0}}, qe};
        rem = {1'b0, n};
        for (int k = 0; k < BPS; k++) begin
            if (rem >= {1'b0, s.ct}) begin
                s.c = s.c << s.ct;
                rem = rem - {1'b0, s.ct};
                b   = byte_step(s);
                s   = b.st;
                r.fire[k]        = b.fire;
                r.bytes[k*8 +: 8] = b.byte_out;
            end
        end
        r.spill = (rem >= {1'b0, s.ct});
        if (!r.spill) begin
            s.c  = s.c << rem;
            s.ct = s.ct - rem[CT_W-1:0];
        end
        r.st = s;
        return r;
    endfunction

    // End of block: pad, two boundaries, final held byte unless 0xFF.
    function automatic fl_t flush_step(coder_t s_in, logic [QE_W-1:0] ival);
        fl_t            r;
        coder_t         t;
        bo_t            b0;
        bo_t            b1;
        logic [C_W-1:0] upper;
        logic [C_W-1:0] pad;
        upper = s_in.c + {{(C_W-QE_W){1'b0}}, ival};
        pad   = s_in.c | PAD_ONES;
        if (pad >= upper) pad = pad - PAD_HALF;
        t     = s_in;
        t.c   = pad << t.ct;
        b0    = byte_step(t);
        t     = b0.st;
        t.c   = t.c << t.ct;
        b1    = byte_step(t);
        t     = b1.st;
        r.bytes = {t.hold, b1.byte_out, b0.byte_out};
        r.fire  = {t.live && (t.hold != 8'hFF), b1.fire, b0.fire};
        return r;
    endfunction

endpackage

// File: rtl/mqce_symbol_stage.sv
module mqce_symbol_stage
    import mqce_pkg::*;
(
    input  coder_t            st_in,
    input  logic [QE_W-1:0]   qe,
    input  logic              is_mps,
    input  logic [SH_W-1:0]   nshift,
    output coder_t            st_out,
    output logic [BPS*8-1:0]  bytes,
    output logic [BPS-1:0]    fire,
    output logic              spill
);
    sym_t res;

    always_comb res = sym_step(st_in, qe, is_mps, nshift);

    assign st_out = res.st;
    assign bytes  = res.bytes;
    assign fire   = res.fire;
    assign spill  = res.spill;
endmodule

// File: rtl/mqce_flush_stage.sv
module mqce_flush_stage
    import mqce_pkg::*;
(
    input  coder_t          st_in,
    input  logic [QE_W-1:0] ival,
    output logic [23:0]     bytes,
    output logic [2:0]      fire
);
    fl_t res;

    always_comb res = flush_step(st_in, ival);

    assign bytes = res.bytes;
    assign fire  = res.fire;
endmodule

// File: rtl/mqce_lane_pack.sv
module mqce_lane_pack #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] slot_byte,
    input  logic [LANES-1:0]   slot_fire,
    output logic [LANES*8-1:0] lane_byte,
    output logic [LANES-1:0]   lane_vld
);
    always_comb begin
        int idx;
        idx       = 0;
        lane_byte = '0;
        lane_vld  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (slot_fire[i]) begin
                lane_byte[idx*8 +: 8] = slot_byte[i*8 +: 8];
                lane_vld[idx]         = 1'b1;
                idx                   = idx + 1;
            end
        end
    end
endmodule

// File: rtl/mq_dual_emitter.sv
module mq_dual_emitter
    import mqce_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        flush,
    input  logic [15:0] sym0_qe,
    input  logic        sym0_mps,
    input  logic [3:0]  sym0_shift,
    input  logic [15:0] sym1_qe,
    input  logic        sym1_mps,
    input  logic [3:0]  sym1_shift,
    input  logic [15:0] flush_ival,
    output logic [31:0] lane_byte,
    output logic [3:0]  lane_vld
);
    localparam int NSYM  = 2;
    localparam int LANES = NSYM * BPS;

    coder_t                st_q;
    coder_t                chain [NSYM+1];
    logic [QE_W-1:0]       qe_v  [NSYM];
    logic                  mps_v [NSYM];
    logic [SH_W-1:0]       sh_v  [NSYM];
    logic [NSYM-1:0]       spill_v;
    logic [LANES*8-1:0]    pair_bytes;
    logic [LANES-1:0]      pair_fire;
    logic [23:0]           fl_bytes;
    logic [2:0]            fl_fire;
    logic [LANES*8-1:0]    slot_byte;
    logic [LANES-1:0]      slot_fire;
    logic [LANES*8-1:0]    pk_byte;
    logic [LANES-1:0]      pk_vld;

    assign qe_v[0]  = sym0_qe;
    assign qe_v[1]  = sym1_qe;
    assign mps_v[0] = sym0_mps;
    assign mps_v[1] = sym1_mps;
    assign sh_v[0]  = sym0_shift;
    assign sh_v[1]  = sym1_shift;
    assign chain[0] = st_q;

    for (genvar g = 0; g < NSYM; g++) begin : g_sym
        mqce_symbol_stage u_stage (
            .st_in  (chain[g]),
            .qe     (qe_v[g]),
            .is_mps (mps_v[g]),
            .nshift (sh_v[g]),
            .st_out (chain[g+1]),
            .bytes  (pair_bytes[g*BPS*8 +: BPS*8]),
            .fire   (pair_fire[g*BPS +: BPS]),
            .spill  (spill_v[g])
        );
    end

    mqce_flush_stage u_flush (
        .st_in (st_q),
        .ival  (flush_ival),
        .bytes (fl_bytes),
        .fire  (fl_fire)
    );

    always_comb begin
        if (flush) begin
            slot_byte = {{(LANES*8-24){1'b0}}, fl_bytes};
            slot_fire = {{(LANES-3){1'b0}}, fl_fire};
        end else begin
            slot_byte = pair_bytes;
            slot_fire = pair_fire;
        end
    end

    mqce_lane_pack #(.LANES(LANES)) u_pack (
        .slot_byte (slot_byte),
        .slot_fire (slot_fire),
        .lane_byte (pk_byte),
        .lane_vld  (pk_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= CODER_INIT;
            lane_byte <= '0;
            lane_vld  <= '0;
        end else if (flush) begin
            st_q      <= CODER_INIT;
            lane_byte <= pk_byte;
            lane_vld  <= pk_vld;
        end else if (in_valid) begin
            st_q      <= chain[NSYM];
            lane_byte <= pk_byte;
            lane_vld  <= pk_vld;
        end else begin
            lane_vld  <= '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> lane_vld == '0);

    // R3
    ct_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ct != '0) && (st_q.ct <= CT_START));

    // R8
    lane_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_vld & (lane_vld + 4'd1)) == '0);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(flush)) |-> lane_vld == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush) |=> $stable(st_q));

    // R10
    flush_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> !lane_vld[3]);

    // R10
    flush_restart_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (st_q.ct == CT_START) && (st_q.c == '0) && !st_q.live);

    // R8
    no_spill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush) |-> spill_v == '0);

    // R10
    excl_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && flush));

endmodule

// File: tb/mq_dual_emitter_test.sv
module mq_dual_emitter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] sym0_qe = '0;
    logic        sym0_mps = 1'b0;
    logic [3:0]  sym0_shift = '0;
    logic [15:0] sym1_qe = '0;
    logic        sym1_mps = 1'b0;
    logic [3:0]  sym1_shift = '0;
    logic [15:0] flush_ival = '0;
    logic [31:0] lane_byte;
    logic [3:0]  lane_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mq_dual_emitter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush),
        .sym0_qe(sym0_qe), .sym0_mps(sym0_mps), .sym0_shift(sym0_shift),
        .sym1_qe(sym1_qe), .sym1_mps(sym1_mps), .sym1_shift(sym1_shift),
        .flush_ival(flush_ival), .lane_byte(lane_byte), .lane_vld(lane_vld)
    );

    // Reference coder, one shift at a time.
    logic [31:0] m_c;
    int          m_ct;
    logic [7:0]  m_b;
    bit          m_live;
    logic [7:0]  exp_b [4];
    int          exp_n;

    task automatic m_reset();
        m_c = '0; m_ct = 12; m_b = 8'h00; m_live = 1'b0;
    endtask

    task automatic m_put(logic [7:0] v);
        if (m_live) begin
            exp_b[exp_n] = v;
            exp_n++;
        end
        m_live = 1'b1;
    endtask

    task automatic m_boundary();
        if (m_b == 8'hFF) begin
            m_put(m_b); m_b = m_c[27:20]; m_c = m_c & 32'h000F_FFFF; m_ct = 7;
        end else if (m_c < 32'h0800_0000) begin
            m_put(m_b); m_b = m_c[26:19]; m_c = m_c & 32'h0007_FFFF; m_ct = 8;
        end else begin
            m_b = m_b + 8'd1;
            if (m_b == 8'hFF) begin
                m_c = m_c & 32'h07FF_FFFF;
                m_put(m_b); m_b = m_c[27:20]; m_c = m_c & 32'h000F_FFFF; m_ct = 7;
            end else begin
                m_put(m_b); m_b = m_c[26:19]; m_c = m_c & 32'h0007_FFFF; m_ct = 8;
            end
        end
    endtask

    task automatic m_symbol(logic [15:0] qe, logic mps, int n);
        if (mps) m_c = m_c + {16'h0, qe};
        for (int i = 0; i < n; i++) begin
            m_c = m_c << 1;
            m_ct--;
            if (m_ct == 0) m_boundary();
        end
    endtask

    task automatic m_flush(logic [15:0] a);
        logic [31:0] up;
        up  = m_c + {16'h0, a};
        m_c = m_c | 32'h0000_FFFF;
        if (m_c >= up) m_c = m_c - 32'h0000_8000;
        m_c = m_c << m_ct; m_boundary();
        m_c = m_c << m_ct; m_boundary();
        if (m_b != 8'hFF) begin
            exp_b[exp_n] = m_b;
            exp_n++;
        end
        m_reset();
    endtask

    task automatic check_out(string tag);
        logic [3:0] emask;
        emask = 4'((1 << exp_n) - 1);
        checks++;
        if (lane_vld !== emask) begin
            errors++;
            $display("FAIL %s lane_vld actual %b expected %b", tag, lane_vld, emask);
        end
        for (int k = 0; k < exp_n; k++) begin
            checks++;
            if (lane_byte[k*8 +: 8] !== exp_b[k]) begin
                errors++;
                $display("FAIL %s lane %0d actual %02h expected %02h",
                         tag, k, lane_byte[k*8 +: 8], exp_b[k]);
            end
        end
    endtask

    task automatic check_lit(int k, logic [7:0] v, string tag);
        checks++;
        if (lane_vld[k] !== 1'b1 || lane_byte[k*8 +: 8] !== v) begin
            errors++;
            $display("FAIL %s lane %0d actual %b/%02h expected 1/%02h",
                     tag, k, lane_vld[k], lane_byte[k*8 +: 8], v);
        end
    endtask

    task automatic do_pair(logic [41:0] v, string tag);
        @(negedge clk);
        {sym0_qe, sym0_mps, sym0_shift, sym1_qe, sym1_mps, sym1_shift} = v;
        in_valid = 1'b1;
        exp_n = 0;
        m_symbol(v[41:26], v[25], int'(v[24:21]));
        m_symbol(v[20:5], v[4], int'(v[3:0]));
        @(negedge clk);
        in_valid = 1'b0;
        check_out(tag);
    endtask

    task automatic do_flush(logic [15:0] a, string tag);
        @(negedge clk);
        flush = 1'b1;
        flush_ival = a;
        exp_n = 0;
        m_flush(a);
        @(negedge clk);
        flush = 1'b0;
        check_out(tag);
    endtask

    function automatic logic [41:0] pv(logic [15:0] q0, logic p0, int s0,
                                       logic [15:0] q1, logic p1, int s1);
        return {q0, p0, 4'(s0), q1, p1, 4'(s1)};
    endfunction

    localparam logic [41:0] VEC [16] = '{
        {16'h5601, 1'b1, 4'd1,  16'h3401, 1'b1, 4'd2},
        {16'h1801, 1'b0, 4'd3,  16'h0AC1, 1'b1, 4'd0},
        {16'h0521, 1'b0, 4'd5,  16'h0221, 1'b0, 4'd6},
        {16'h5401, 1'b1, 4'd1,  16'h4801, 1'b0, 4'd1},
        {16'h3801, 1'b1, 4'd0,  16'h3001, 1'b1, 4'd1},
        {16'h0009, 1'b0, 4'd13, 16'h0005, 1'b0, 4'd14},
        {16'h2401, 1'b1, 4'd2,  16'h1C01, 1'b0, 4'd3},
        {16'h1601, 1'b0, 4'd3,  16'h5101, 1'b1, 4'd1},
        {16'h0001, 1'b0, 4'd14, 16'h2801, 1'b1, 4'd0},
        {16'h2201, 1'b1, 4'd2,  16'h1401, 1'b0, 4'd4},
        {16'h7FFF, 1'b1, 4'd9,  16'h7F80, 1'b1, 4'd11},
        {16'h1201, 1'b0, 4'd4,  16'h1101, 1'b1, 4'd0},
        {16'h09C1, 1'b0, 4'd6,  16'h08A1, 1'b0, 4'd6},
        {16'h0441, 1'b1, 4'd0,  16'h02A1, 1'b0, 4'd8},
        {16'h0141, 1'b0, 4'd9,  16'h0111, 1'b0, 4'd10},
        {16'h0085, 1'b1, 4'd1,  16'h0049, 1'b0, 4'd12}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        m_reset();
        exp_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, no lanes
        check_out("R1 reset");

        // R1 R2 R4 R7: first boundary at 12 shifts, placeholder dropped
        do_pair(pv(16'h5601, 1, 0, 16'h0000, 0, 12), "R1 first boundary");
        do_pair(pv(16'h0000, 0, 8, 16'h0000, 0, 0), "R4 R7 held byte");
        check_lit(0, 8'hAC, "R2 R4 byte from C[26:19]");
        do_flush(16'h8000, "R10 flush a");

        // R5: 0xFF then a 7-shift byte in the same pair
        do_pair(pv(16'h7F80, 1, 12, 16'h0000, 0, 0), "R5 make FF");
        do_pair(pv(16'h7FFF, 1, 8, 16'h0000, 0, 7), "R5 stuffed pair");
        check_lit(0, 8'hFF, "R5 FF released");
        check_lit(1, 8'h07, "R5 byte after 7 shifts");
        do_flush(16'hC000, "R10 flush b");

        // R6: carry into 0xFE becomes 0xFF
        do_pair(pv(16'h7F00, 1, 12, 16'h0000, 0, 0), "R6 make FE");
        for (int i = 0; i < 5; i++)
            do_pair(pv(16'hFFFF, 1, 0, 16'hFFFF, 1, 0), "R2 accumulate");
        do_pair(pv(16'h0000, 0, 8, 16'h0000, 0, 0), "R6 carry");
        check_lit(0, 8'hFF, "R6 carried byte");

        // R9: idle cycles release nothing, state kept
        repeat (3) @(negedge clk);
        exp_n = 0;
        check_out("R9 idle");
        do_flush(16'h9000, "R10 flush c");

        // R8: four bytes in one pair
        do_pair(pv(16'h0000, 0, 12, 16'h0000, 0, 0), "R8 prime");
        do_pair(pv(16'h0000, 0, 7, 16'h0000, 0, 0), "R3 partial shift");
        do_pair(pv(16'h3401, 1, 15, 16'h1801, 1, 10), "R8 four bytes");
        checks++;
        if (lane_vld !== 4'b1111) begin
            errors++;
            $display("FAIL R8 lane_vld actual %b expected 1111", lane_vld);
        end
        do_flush(16'hA000, "R10 flush d");

        // R3 R8 R11: table walk
        foreach (VEC[i]) do_pair(VEC[i], "R8 table");
        do_flush(16'h8801, "R10 flush table");

        // R6 R8 R10: pseudo-random pairs
        lf = 32'h1234_5679;
        for (int i = 0; i < 600; i++) begin
            logic [15:0] q0;
            logic [15:0] q1;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            q0 = {1'b0, lf[14:0]} | 16'h1;
            q1 = {1'b0, lf[30:16]} | 16'h1;
            do_pair(pv(q0, lf[15], int'(lf[19:16]) % 15, q1, lf[31], int'(lf[27:24]) % 15),
                    "R3 random");
            if (i % 60 == 59) do_flush(16'h8000 | {1'b0, lf[14:0]}, "R10 random flush");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule